// File: doc/BRIEF.md
# MDIO Management Command Controller

The block gives a host a single 32-bit command/status word through which it reaches the management registers of an external PHY. A host write to the word launches one clause-22 style management frame on the MDC/MDIO pair. For a write, that one host write carries the opcode, both addresses and the 16-bit value. For a read, the host writes the command and then reads the word repeatedly until the read-valid flag is 1. At that point the data field holds the value the PHY returned, and the flag drops after the read that saw it. MDC is a free-running divided copy of the system clock. The block drives MDIO through an output/enable pair so that it can be tri-stated outside the chip.

A frame controller steps through seven named states:
- `ST_IDLE` waits for an accepted command and moves to `ST_ARM`.
- `ST_ARM` waits for the next falling MDC edge and moves to `ST_PRE`.
- `ST_PRE` sends 32 ones and then moves to `ST_HDR`.
- `ST_HDR` sends 14 bits (start, opcode, PHY address, register address) and then moves to `ST_TURN`.
- `ST_TURN` covers the 2 turnaround bits and then moves to `ST_DATA`.
- `ST_DATA` covers the 16 data bits. At its end a read returns to `ST_IDLE`, and a write moves to `ST_SPACE`.
- `ST_SPACE` holds the block busy for the post-write spacing in MDC cycles and then returns to `ST_IDLE`.

Each bit, and each move between states, happens on a falling MDC edge.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the word reads 0x0400_0000 (opcode 1, addresses 0, data 0, read-valid 0), `busy` is 0 and `mdio_oe` is 0.
- R2: Field layout of the word: data in bits 15:0, PHY address in 20:16, register address in 25:21, opcode in 26 (0 = write, 1 = read), read-valid in 27. Bits 31:28 always read as 0, whatever was written to them.
- R3: MDC runs continuously with a period of 2*HALF_DIV system clocks.
- R4: Every frame begins with 32 driven ones. These are followed by start bits 0,1, then opcode bits 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register address, each sent MSB first.
- R5: A write frame drives turnaround bits 1,0 and then the 16 data bits, MSB first.
- R6: A read frame releases MDIO (`mdio_oe` = 0) for the turnaround and data bits. It samples 16 bits MSB first on rising MDC edges, places them in the data field and sets read-valid.
- R7: `mdio_o` and `mdio_oe` change only in the clock cycle in which MDC falls.
- R8: Read-valid clears on the cycle after a host read that returned it as 1. Accepting a new command also clears it.
- R9: `busy` rises in the cycle after a command is accepted. After a write it stays high through the frame and then for SPACING_MDC (default 320) further MDC cycles.
- R10: A host write while `busy` is 1 is ignored: no frame starts, and the fields already held are unchanged.
- R11: A read frame has no spacing period: `busy` falls within one MDC cycle of the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle host write strobe for the command word |
| host_rd | input | 1 | One-cycle host read strobe; a read that sees read-valid clears it |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Current command/status word (combinational view) |
| busy | output | 1 | A frame or the post-write spacing is in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; 0 means high impedance |

## Verification
The assertions assume that `host_wr` and `host_rd` are one-cycle strobes applied between clock edges. They also assume that the PHY drives MDIO only inside the release window of a read frame, so that a read completion never lands in the same cycle as a host read of a set flag. The bench drives every strobe from the falling system-clock edge for exactly one cycle. Its PHY responder decodes frames from the MDIO line and drives only from the second turnaround bit to the last data bit of a read. It also counts any overlap with `mdio_oe`, so a breach of this assumption shows up as a failed check.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA,
        ST_SPACE
    } mdio_state_t;

    localparam int unsigned HDR_BITS  = 14;
    localparam int unsigned TA_BITS   = 2;
    localparam int unsigned DATA_BITS = 16;
    localparam int unsigned ADDR_BITS = 5;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OPC_READ   = 2'b10;
    localparam logic [1:0] OPC_WRITE  = 2'b01;
    localparam logic [1:0] TA_WRITE   = 2'b10;

    localparam int unsigned F_DATA_LO = 0;
    localparam int unsigned F_PHY_LO  = 16;
    localparam int unsigned F_REG_LO  = 21;
    localparam int unsigned F_OP      = 26;
    localparam int unsigned F_VALID   = 27;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          wrap;

    assign wrap      = (div_cnt == LAST);
    assign rise_tick = wrap & ~mdc;
    assign fall_tick = wrap & mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            mdc     <= ~mdc;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_BITS    = 32,
    parameter int unsigned SPACING_MDC = 320
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cmd_read,
    input  logic [ADDR_BITS-1:0] cmd_phy,
    input  logic [ADDR_BITS-1:0] cmd_reg,
    input  logic [DATA_BITS-1:0] cmd_data,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 busy,
    output logic                 rd_done,
    output logic [DATA_BITS-1:0] rd_data
);
    localparam int unsigned MAXC  = (SPACING_MDC > PRE_BITS) ? SPACING_MDC : PRE_BITS;
    localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam int unsigned TX_W  = HDR_BITS + TA_BITS + DATA_BITS;

    mdio_state_t          state, state_d;
    logic [CNT_W-1:0]     bit_cnt, bit_lim;
    logic                 bit_last;
    logic [TX_W-1:0]      tx_sr;
    logic [DATA_BITS-1:0] rx_sr;
    logic                 is_read;

    always_comb begin
        unique case (state)
            ST_PRE:   bit_lim = CNT_W'(PRE_BITS - 1);
            ST_HDR:   bit_lim = CNT_W'(HDR_BITS - 1);
            ST_TURN:  bit_lim = CNT_W'(TA_BITS - 1);
            ST_DATA:  bit_lim = CNT_W'(DATA_BITS - 1);
            ST_SPACE: bit_lim = CNT_W'(SPACING_MDC - 1);
            default:  bit_lim = '0;
        endcase
        bit_last = fall_tick && (bit_cnt == bit_lim);
    end

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (start)     state_d = ST_ARM;
            ST_ARM:   if (fall_tick) state_d = ST_PRE;
            ST_PRE:   if (bit_last)  state_d = ST_HDR;
            ST_HDR:   if (bit_last)  state_d = ST_TURN;
            ST_TURN:  if (bit_last)  state_d = ST_DATA;
            ST_DATA:  if (bit_last)  state_d = is_read ? ST_IDLE : ST_SPACE;
            ST_SPACE: if (bit_last)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            is_read <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
                if (start) begin
                    is_read <= cmd_read;
                    tx_sr   <= {START_CODE, (cmd_read ? OPC_READ : OPC_WRITE),
                                cmd_phy, cmd_reg, TA_WRITE, cmd_data};
                end
            end
            if (rise_tick && state == ST_DATA && is_read)
                rx_sr <= {rx_sr[DATA_BITS-2:0], mdio_i};
            if (fall_tick) begin
                bit_cnt <= (bit_last || state == ST_ARM) ? '0 : bit_cnt + 1'b1;
                unique case (state)
                    ST_ARM: begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b1;
                    end
                    ST_PRE: begin
                        if (bit_last) begin
                            mdio_o <= tx_sr[TX_W-1];
                            tx_sr  <= tx_sr << 1;
                        end
                    end
                    ST_HDR, ST_TURN, ST_DATA: begin
                        if (state == ST_DATA && bit_last) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b1;
                            rd_done <= is_read;
                        end else begin
                            mdio_o <= tx_sr[TX_W-1];
                            tx_sr  <= tx_sr << 1;
                            if (is_read && (state == ST_TURN || bit_last))
                                mdio_oe <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy    = (state != ST_IDLE) || rd_done;
    assign rd_data = rx_sr;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 4,
    parameter int unsigned PRE_BITS    = 32,
    parameter int unsigned SPACING_MDC = 320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        busy,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic                 rise_tick, fall_tick;
    logic                 accept;
    logic                 rd_done;
    logic [DATA_BITS-1:0] rd_data;
    logic [DATA_BITS-1:0] f_data;
    logic [ADDR_BITS-1:0] f_phy, f_reg;
    logic                 f_op, f_valid;

    assign accept = host_wr && !busy;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm #(.PRE_BITS(PRE_BITS), .SPACING_MDC(SPACING_MDC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .cmd_read  (host_wdata[F_OP]),
        .cmd_phy   (host_wdata[F_PHY_LO +: ADDR_BITS]),
        .cmd_reg   (host_wdata[F_REG_LO +: ADDR_BITS]),
        .cmd_data  (host_wdata[F_DATA_LO +: DATA_BITS]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_data  <= '0;
            f_phy   <= '0;
            f_reg   <= '0;
            f_op    <= 1'b1;
            f_valid <= 1'b0;
        end else if (accept) begin
            f_data  <= host_wdata[F_DATA_LO +: DATA_BITS];
            f_phy   <= host_wdata[F_PHY_LO +: ADDR_BITS];
            f_reg   <= host_wdata[F_REG_LO +: ADDR_BITS];
            f_op    <= host_wdata[F_OP];
            f_valid <= 1'b0;
        end else if (rd_done) begin
            f_data  <= rd_data;
            f_valid <= 1'b1;
        end else if (host_rd && f_valid) begin
            f_valid <= 1'b0;
        end
    end

    assign host_rdata = {4'h0, f_valid, f_op, f_reg, f_phy, f_data};
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [31:0] host_rdata,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R2: reserved bits read back as zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[31:28] == 4'h0);

    // R7: MDIO pins move only with a falling MDC
    p_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));

    // R8: a host read that sees read-valid clears it
    p_valid_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_rdata[27]) |=> !host_rdata[27]);

    // R9: MDIO is released whenever no operation is in progress
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R10: a write during busy leaves the held fields alone
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> $stable(host_rdata[26:16]));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .busy       (busy),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/tb_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_cmd_ctrl;
    localparam int HALF_DIV = 4;
    localparam int SPACING  = 320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        phy_oe = 1'b0;
    logic        phy_val = 1'b1;
    wire         mdio_bus = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int contention = 0;
    int edge_viol = 0;
    int busy_rises = 0;

    always #10 clk = ~clk;

    mdio_cmd_ctrl #(.HALF_DIV(HALF_DIV), .SPACING_MDC(SPACING)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .mdc(mdc), .mdio_i(mdio_bus), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // ---------------- PHY responder ----------------
    int          ph = 0, ones = 0, k = 0, pre_seen = 0;
    int          wr_count = 0, rd_count = 0;
    logic [11:0] hdr = '0, nh;
    logic [17:0] wsr = '0;
    logic [4:0]  wr_phy, wr_reg;
    logic [15:0] wr_data, resp_now = '0;
    logic [1:0]  wr_ta;

    function automatic logic [15:0] resp_of(input logic [4:0] p, input logic [4:0] r);
        return {3'b101, p, r, 3'b011};
    endfunction

    always @(posedge mdc) begin
        if (busy) busy_rises++;
        case (ph)
            0: begin
                if (mdio_oe && mdio_bus) ones++;
                else if (mdio_oe && !mdio_bus && ones >= 32) begin
                    pre_seen = ones; ph = 1;
                end else ones = 0;
            end
            1: begin
                if (mdio_bus) begin ph = 2; k = 0; end
                else begin ph = 0; ones = 0; end
            end
            2: begin
                nh = {hdr[10:0], mdio_bus};
                hdr = nh;
                k++;
                if (k == 12) begin
                    k = 0;
                    if (nh[11:10] == 2'b10) begin
                        ph = 3; resp_now = resp_of(nh[9:5], nh[4:0]);
                    end else if (nh[11:10] == 2'b01) ph = 4;
                    else begin ph = 0; ones = 0; end
                end
            end
            3: begin
                k++;
                if (k == 18) begin ph = 0; ones = 0; rd_count++; end
            end
            4: begin
                wsr = {wsr[16:0], mdio_bus};
                k++;
                if (k == 18) begin
                    wr_ta = wsr[17:16]; wr_data = wsr[15:0];
                    wr_phy = hdr[9:5]; wr_reg = hdr[4:0];
                    wr_count++; ph = 0; ones = 0;
                end
            end
            default: ph = 0;
        endcase
    end

    always @(negedge mdc) begin
        if (ph == 3 && k == 1) begin phy_oe <= 1'b1; phy_val <= 1'b0; end
        else if (ph == 3 && k >= 2 && k <= 17) begin
            phy_oe <= 1'b1; phy_val <= resp_now[17-k];
        end else phy_oe <= 1'b0;
    end

    always @(negedge clk) if (mdio_oe && phy_oe) contention++;

    always @(mdio_o or mdio_oe) begin
        #1;
        if (rst_n && mdc !== 1'b0) edge_viol++;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic logic [31:0] mk(input logic op, input logic [4:0] p,
                                       input logic [4:0] r, input logic [15:0] d);
        return {4'h0, 1'b0, op, r, p, d};
    endfunction

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_wdata = w; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] v);
        @(negedge clk);
        host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        check("R1 busy after reset", {31'b0, busy}, 32'h0);
        check("R1 mdio_oe after reset", {31'b0, mdio_oe}, 32'h0);
        host_read(v);
        check("R1 reset word", v, 32'h0400_0000);
    endtask

    task automatic t_mdc_period();
        realtime t0, t1;
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        check("R3 mdc period ns", int'(t1 - t0), 2 * HALF_DIV * 20);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int wc0 = wr_count;
        host_write(mk(1'b0, 5'h05, 5'h11, 16'hBEEF));
        busy_rises = 0;
        check("R9 busy after accept", {31'b0, busy}, 32'h1);
        wait_idle();
        check("R5 write frame count", wr_count, wc0 + 1);
        check("R4 preamble ones", pre_seen, 32);
        check("R4 write phy addr", {27'b0, wr_phy}, 32'h05);
        check("R4 write reg addr", {27'b0, wr_reg}, 32'h11);
        check("R5 write turnaround", {30'b0, wr_ta}, 32'h2);
        check("R5 write data", {16'b0, wr_data}, 32'hBEEF);
        check_rng("R9 busy mdc cycles after write", busy_rises, 64 + SPACING, 65 + SPACING);
        host_read(v);
        check("R2 fields after write", v, mk(1'b0, 5'h05, 5'h11, 16'hBEEF));
    endtask

    task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [31:0] extra);
        logic [31:0] v;
        int rc0 = rd_count;
        host_write(mk(1'b1, p, r, 16'h0) | extra);
        busy_rises = 0;
        repeat (100) @(negedge clk);
        host_read(v);
        check("R6 valid low mid-read", {31'b0, v[27]}, 32'h0);
        wait_idle();
        check_rng("R11 busy mdc cycles on read", busy_rises, 64, 66);
        check("R4 read frame seen", rd_count, rc0 + 1);
        host_read(v);
        check("R2 reserved bits zero", {28'b0, v[31:28]}, 32'h0);
        check("R6 valid set", {31'b0, v[27]}, 32'h1);
        check("R6 read data", {16'b0, v[15:0]}, {16'b0, resp_of(p, r)});
        check("R2 read fields", {21'b0, v[26:16]}, {21'b0, 1'b1, r, p});
        host_read(v);
        check("R8 valid cleared by read", {31'b0, v[27]}, 32'h0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        int wc0 = wr_count;
        int rc0 = rd_count;
        host_write(mk(1'b0, 5'h09, 5'h02, 16'h1234));
        repeat (50) @(negedge clk);
        host_write(mk(1'b1, 5'h1F, 5'h1F, 16'hFFFF));
        host_read(v);
        check("R10 fields kept during busy", v[26:0], mk(1'b0, 5'h09, 5'h02, 16'h1234) & 32'h07FF_FFFF);
        wait_idle();
        check("R10 one write frame", wr_count, wc0 + 1);
        check("R10 no read frame", rd_count, rc0);
        check("R10 first frame data", {16'b0, wr_data}, 32'h1234);
    endtask

    task automatic t_launch_clear();
        logic [31:0] v;
        host_write(mk(1'b1, 5'h02, 5'h04, 16'h0));
        wait_idle();
        host_write(mk(1'b0, 5'h02, 5'h04, 16'h0F0F));
        host_read(v);
        check("R8 launch clears valid", {31'b0, v[27]}, 32'h0);
        wait_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mdc_period();
        t_write();
        t_read(5'h03, 5'h07, 32'h0);
        t_read(5'h1F, 5'h1F, 32'hF800_0000);
        t_ignore();
        t_launch_clear();
        check("R7 pin changes off falling mdc", edge_viol, 0);
        check("R6 bus contention", contention, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog R9 actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule